// File: doc/BRIEF.md
# UART status flags with guarded clear

This block keeps two sticky status bits for a FIFO-buffered UART: a receive-error flag and a transmit-end flag. The receiver reports every finished character with a one-cycle event that carries the sampled data, parity bit and stop bit. The block checks the character for a framing fault and, when parity is enabled, for a parity fault. It returns per-character fault tags in the same cycle so that they can be pushed into the receive FIFO next to the data. Any fault also sets the receive-error flag. The character itself is never dropped.

The transmitter reports when the last bit of a character has left the shifter, and it supplies the transmit FIFO empty level. From these the block keeps the transmit-end flag. That flag is also held at 1 while the transmitter is disabled, and a DMA write into the transmit FIFO clears it.

Software clears a flag only through a handshake. It first reads the flag as 1, which arms that flag. A following write of 0 to the flag's bit then clears it. Each flag drives an interrupt request through its own enable input.

Top module: `uart_status_flags`

## Requirements
- R1: A character event (`rx_done_i`) with `rx_en_i`=1 and `rx_stop_i`=0 asserts `rx_fer_tag_o` in the same cycle and sets the receive-error flag (register bit 0) on the next clock edge.
- R2: With `par_en_i`=1, a parity fault asserts `rx_per_tag_o` in the same cycle and sets the receive-error flag. A parity fault is present when the XOR of `rx_data_i` and `rx_par_i` is 1 for even parity (`par_odd_i`=0), or 0 for odd parity (`par_odd_i`=1).
- R3: With `par_en_i`=0, `rx_per_tag_o` stays 0 and a parity mismatch alone does not set the receive-error flag.
- R4: While `rx_en_i`=0, character events are ignored: both tags stay 0 and the receive-error flag keeps its value.
- R5: Reset gives `reg_rdata_o` = 2'b10, that is, the receive-error flag is 0 and the transmit-end flag (bit 1) is 1.
- R6: A read (`reg_rd_i`) that returns a flag as 1 arms that flag. Any write (`reg_wr_i`) disarms both flags. Writing 0 to an armed flag's bit clears it. Writing 0 to an unarmed flag has no effect, and writing 1 never changes a flag.
- R7: While `tx_en_i`=0, the transmit-end flag is 1 from the next clock edge on.
- R8: `tx_last_bit_i` sets the transmit-end flag when `tx_fifo_empty_i`=1. When the FIFO is not empty, `tx_last_bit_i` has no effect.
- R9: The software clear of the transmit-end flag takes effect only while `tx_fifo_empty_i`=0. A `dma_tx_wr_i` pulse clears the flag without any handshake.
- R10: When a set condition and a valid clear meet in the same cycle, the flag ends at 1.
- R11: `rx_err_irq_o` equals the receive-error flag AND `rx_ie_i`, and `tx_end_irq_o` equals the transmit-end flag AND `tx_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| rx_done_i | input | 1 | End-of-character event from the receiver |
| rx_data_i | input | DATA_W | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_stop_i | input | 1 | Sampled stop bit |
| par_en_i | input | 1 | Parity checking enabled |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_fer_tag_o | output | 1 | Framing-fault tag for the current character |
| rx_per_tag_o | output | 1 | Parity-fault tag for the current character |
| tx_en_i | input | 1 | Transmitter enable |
| tx_last_bit_i | input | 1 | Last bit of a character shifted out |
| tx_fifo_empty_i | input | 1 | Transmit FIFO holds no data |
| dma_tx_wr_i | input | 1 | DMA write into the transmit FIFO |
| reg_rd_i | input | 1 | CPU read strobe of the status register |
| reg_wr_i | input | 1 | CPU write strobe of the status register |
| reg_wdata_i | input | 2 | Write data; bit 0 receive error, bit 1 transmit end |
| reg_rdata_o | output | 2 | Flag bits; bit 0 receive error, bit 1 transmit end |
| rx_ie_i | input | 1 | Receive-error interrupt enable |
| tx_ie_i | input | 1 | Transmit-end interrupt enable |
| rx_err_irq_o | output | 1 | Receive-error interrupt request |
| tx_end_irq_o | output | 1 | Transmit-end interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware set of a flag and a software write of 0 that would clear it. The bench arms the receive-error flag with a read, then drives the clearing write in the same cycle as a character whose stop bit is 0. It expects the flag to read back as 1. For the transmit-end flag, it presents a last-bit event with an empty FIFO in the same cycle as a DMA write, and again expects 1.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int REG_W      = 2;
  localparam int RX_ERR_BIT = 0;
  localparam int TX_END_BIT = 1;
endpackage

// File: rtl/uart_rx_check.sv
module uart_rx_check #(
  parameter int DATA_W = 8
) (
  input  logic              en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              stop_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              fer_o,
  output logic              per_o
);
  logic evt;
  logic ones_odd;

  assign evt      = en_i & done_i;
  assign ones_odd = ^{data_i, par_i};
  assign fer_o    = evt & ~stop_i;
  // mismatch: odd count under even sense, or even count under odd sense
  assign per_o    = evt & par_en_i & (ones_odd != par_odd_i);
endmodule

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic clr_ok_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, armed_q, sw_clr;

  assign sw_clr = wr_i & ~wbit_i & armed_q & clr_ok_i;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      if (force_i | set_i)        flag_q <= 1'b1;
      else if (sw_clr | hw_clr_i) flag_q <= 1'b0;
      if (wr_i)                   armed_q <= 1'b0;
      else if (rd_i & flag_q)     armed_q <= 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R10
  AST_UNARMED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !armed_q && !set_i && !force_i && !hw_clr_i) |=> flag_o == $past(flag_o)); // R6
  AST_W1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wbit_i && !set_i && !force_i && !hw_clr_i) |=> flag_o == $past(flag_o)); // R6
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_stop_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              rx_fer_tag_o,
  output logic              rx_per_tag_o,
  input  logic              tx_en_i,
  input  logic              tx_last_bit_i,
  input  logic              tx_fifo_empty_i,
  input  logic              dma_tx_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_wdata_i,
  output logic [1:0]        reg_rdata_o,
  input  logic              rx_ie_i,
  input  logic              tx_ie_i,
  output logic              rx_err_irq_o,
  output logic              tx_end_irq_o
);
  logic rx_err, tx_end;

  uart_rx_check #(.DATA_W(DATA_W)) u_rx_check (
    .en_i      (rx_en_i),
    .done_i    (rx_done_i),
    .data_i    (rx_data_i),
    .par_i     (rx_par_i),
    .stop_i    (rx_stop_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .fer_o     (rx_fer_tag_o),
    .per_o     (rx_per_tag_o)
  );

  uart_flag_cell #(.RST_VAL(1'b0)) u_rx_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .force_i  (1'b0),
    .set_i    (rx_fer_tag_o | rx_per_tag_o),
    .hw_clr_i (1'b0),
    .clr_ok_i (1'b1),
    .rd_i     (reg_rd_i),
    .wr_i     (reg_wr_i),
    .wbit_i   (reg_wdata_i[RX_ERR_BIT]),
    .flag_o   (rx_err)
  );

  uart_flag_cell #(.RST_VAL(1'b1)) u_tx_end (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .force_i  (~tx_en_i),
    .set_i    (tx_last_bit_i & tx_fifo_empty_i),
    .hw_clr_i (dma_tx_wr_i),
    .clr_ok_i (~tx_fifo_empty_i),
    .rd_i     (reg_rd_i),
    .wr_i     (reg_wr_i),
    .wbit_i   (reg_wdata_i[TX_END_BIT]),
    .flag_o   (tx_end)
  );

  always_comb begin
    reg_rdata_o             = '0;
    reg_rdata_o[RX_ERR_BIT] = rx_err;
    reg_rdata_o[TX_END_BIT] = tx_end;
  end

  assign rx_err_irq_o = rx_err & rx_ie_i;
  assign tx_end_irq_o = tx_end & tx_ie_i;

  AST_FER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rx_done_i && !rx_stop_i) |=> reg_rdata_o[RX_ERR_BIT]); // R1
  AST_RX_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !reg_wr_i) |=> $stable(reg_rdata_o[RX_ERR_BIT])); // R4
  AST_RX_OFF_NO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !rx_fer_tag_o && !rx_per_tag_o); // R4
  AST_NO_PAR_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_en_i |-> !rx_per_tag_o); // R3
  AST_TX_OFF_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> reg_rdata_o[TX_END_BIT]); // R7
  AST_TX_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !tx_fifo_empty_i && !reg_wr_i && !dma_tx_wr_i) |=> $stable(reg_rdata_o[TX_END_BIT])); // R8
endmodule

// File: tb/uart_status_flags_bench.sv
module uart_status_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {data[7:0], par, stop, par_en, par_odd, exp_fer, exp_per}
  localparam logic [13:0] VEC [NV] = '{
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h80, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h07, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b1, rx_done = 1'b0, rx_par = 1'b0, rx_stop = 1'b1;
  logic [7:0] rx_data = '0;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic fer, per;
  logic tx_en = 1'b1, tx_last = 1'b0, tx_empty = 1'b1, dma_wr = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [1:0] wdata = '0, rdata;
  logic rx_ie = 1'b0, tx_ie = 1'b0, rx_irq, tx_irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_status_flags #(.DATA_W(8)) u_uart_status_flags (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rx_done_i(rx_done),
    .rx_data_i(rx_data), .rx_par_i(rx_par), .rx_stop_i(rx_stop),
    .par_en_i(par_en), .par_odd_i(par_odd), .rx_fer_tag_o(fer), .rx_per_tag_o(per),
    .tx_en_i(tx_en), .tx_last_bit_i(tx_last), .tx_fifo_empty_i(tx_empty),
    .dma_tx_wr_i(dma_wr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .rx_err_irq_o(rx_irq), .tx_end_irq_o(tx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic reg_read();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] d);
    wr = 1'b1; wdata = d; step(); wr = 1'b0;
  endtask

  task automatic rx_char(input logic [7:0] d, input logic p, input logic s);
    rx_data = d; rx_par = p; rx_stop = s; rx_done = 1'b1;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R5 reset flags", 8'(rdata), 8'h2);
    rst_n = 1'b1; step();
    chk("R5 after reset", 8'(rdata), 8'h2);

    // table walk: tags same cycle, flag next edge, then handshake clear
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      par_en = v[3]; par_odd = v[2];
      rx_char(v[13:6], v[5], v[4]);
      chk($sformatf("R1 fer tag vec%0d", i), 8'(fer), 8'(v[1]));
      chk($sformatf("R2 R3 per tag vec%0d", i), 8'(per), 8'(v[0]));
      step(); rx_done = 1'b0;
      chk($sformatf("R1 R2 R3 flag vec%0d", i), 8'(rdata[0]), 8'(v[1] | v[0]));
      reg_read(); reg_write(2'b10);
      chk($sformatf("R6 clear vec%0d", i), 8'(rdata[0]), 8'h0);
    end

    // R4: receiver off, events ignored
    rx_en = 1'b0; par_en = 1'b1;
    rx_char(8'h01, 1'b0, 1'b0);
    chk("R4 tags off", 8'({fer, per}), 8'h0);
    step(); rx_done = 1'b0;
    chk("R4 flag stays 0", 8'(rdata[0]), 8'h0);
    rx_en = 1'b1;
    rx_char(8'h00, 1'b0, 1'b0); step(); rx_done = 1'b0;
    rx_en = 1'b0; step(); step();
    chk("R4 flag held at 1 with rx off", 8'(rdata[0]), 8'h1);
    rx_en = 1'b1;

    // R6: unarmed write 0, write 1, disarm by write
    reg_write(2'b10);
    chk("R6 unarmed write0", 8'(rdata[0]), 8'h1);
    reg_read(); reg_write(2'b11);
    chk("R6 write1 no change", 8'(rdata[0]), 8'h1);
    reg_write(2'b10);
    chk("R6 disarmed by write", 8'(rdata[0]), 8'h1);

    // R11 interrupts
    rx_ie = 1'b0; #1;
    chk("R11 rx irq masked", 8'(rx_irq), 8'h0);
    rx_ie = 1'b1; #1;
    chk("R11 rx irq on", 8'(rx_irq), 8'h1);

    // R10: armed clear meets a framing fault
    reg_read();
    wr = 1'b1; wdata = 2'b10; rx_char(8'h00, 1'b0, 1'b0);
    step(); wr = 1'b0; rx_done = 1'b0;
    chk("R10 rx set beats clear", 8'(rdata[0]), 8'h1);
    reg_read(); reg_write(2'b10);
    chk("R6 rx clear", 8'(rdata[0]), 8'h0);
    chk("R11 rx irq low", 8'(rx_irq), 8'h0);

    // R9: software clear needs a non-empty FIFO
    tx_empty = 1'b1; reg_read(); reg_write(2'b01);
    chk("R9 empty fifo blocks clear", 8'(rdata[1]), 8'h1);
    tx_empty = 1'b0; reg_read(); reg_write(2'b01);
    chk("R9 sw clear", 8'(rdata[1]), 8'h0);
    tx_ie = 1'b1; #1;
    chk("R11 tx irq low", 8'(tx_irq), 8'h0);

    // R8: last bit with data pending, then with FIFO empty
    tx_last = 1'b1; step(); tx_last = 1'b0;
    chk("R8 busy fifo no set", 8'(rdata[1]), 8'h0);
    tx_empty = 1'b1; tx_last = 1'b1; step(); tx_last = 1'b0;
    chk("R8 set on empty", 8'(rdata[1]), 8'h1);
    chk("R11 tx irq on", 8'(tx_irq), 8'h1);

    // R9: DMA write clears without handshake
    tx_empty = 1'b0; dma_wr = 1'b1; step(); dma_wr = 1'b0;
    chk("R9 dma clear", 8'(rdata[1]), 8'h0);

    // R10: DMA clear and last-bit set together
    tx_empty = 1'b1; tx_last = 1'b1; dma_wr = 1'b1; step();
    tx_last = 1'b0; dma_wr = 1'b0;
    chk("R10 tx set beats dma", 8'(rdata[1]), 8'h1);

    // R7: transmitter disable forces flag
    tx_empty = 1'b0; dma_wr = 1'b1; step(); dma_wr = 1'b0;
    chk("R9 dma clear again", 8'(rdata[1]), 8'h0);
    tx_en = 1'b0; step();
    chk("R7 tx off forces 1", 8'(rdata[1]), 8'h1);
    dma_wr = 1'b1; step(); dma_wr = 1'b0;
    chk("R7 forced over dma", 8'(rdata[1]), 8'h1);
    tx_en = 1'b1;

    // reset mid-run
    rst_n = 1'b0; #1;
    chk("R5 async reset", 8'(rdata), 8'h2);
    step(); rst_n = 1'b1; step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule